// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block decides, during a station search, whether the intermediate frequency coming out of the receiver is where it should be. A sampling timer clocked by the reference clock opens a gate of known length. While the gate is open, every rising edge of the IF signal steps a down counter that was preset to the count a correct IF would produce. When the gate closes, the count left over is read as a signed error and compared with a programmable tolerance. If the error is inside the tolerance, the search-stop flag goes high.

The gate is built from a base period. The base is chosen by the FM/AM mode and is longer in AM. A power-of-two divider after the base sets how many base periods one gate lasts, and an expand bit stretches the gate further. The active length of the counter grows with the gate, so unused high bits of the preset are dropped. Measuring starts only while the PLL reports lock. Gates then follow one another back to back, and the counter reloads the preset at each gate boundary. If lock is lost, the measurement in progress is abandoned and the flag is cleared.

The IF input is sampled in the reference clock domain through a two-stage synchronizer. The reference clock must therefore run at more than twice the IF being counted. In practice this means the counter is fed a pre-scaled IF.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, `search_stop` is low.
- R2: While `pll_lock` is low, no gate runs and `search_stop` is low, even when the other inputs describe a correct frequency.
- R3: In FM mode (`am_mode`=0) a gate lasts BASE_FM_CYC × 2^(`gate_sel` + 4·`gate_ext`) reference cycles. `gate_sel` is a 2-bit value from 0 to 3, and `gate_ext`=1 adds 4 to the exponent.
- R4: In AM mode (`am_mode`=1) the same rule applies with BASE_AM_CYC as the base.
- R5: The counter is preset from `expect_cnt` truncated to L bits. L = LEN_FM_MIN + shift in FM and LEN_AM_MIN + shift in AM, capped at CNT_W, where shift = `gate_sel` + 4·`gate_ext`. The defaults are 11 and 14. Bits of `expect_cnt` at and above position L have no effect on the result.
- R6: Each low-to-high transition of `if_in` inside a gate decrements the counter by one. `if_in` must stay high and low for at least two reference cycles each. The residual at gate end is (`expect_cnt` − edges) modulo 2^L, read as an L-bit two's-complement value, so excess edges give a negative residual.
- R7: At gate end, `search_stop` becomes 1 if |residual| ≤ window and 0 otherwise. The window is WIN_BASE × 2^`win_code` × (4 if `win_ext`=1, else 1). `win_code` is a 2-bit value.
- R8: While locked, `search_stop` changes only at a gate end. Gates repeat back to back with the preset reloaded each time, and `expect_cnt` is sampled only at a gate start.
- R9: When `pll_lock` falls, the running gate is abandoned and `search_stop` is low from the next clock edge. A new lock starts a fresh gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_in | input | 1 | IF signal to be counted (asynchronous) |
| pll_lock | input | 1 | PLL in-lock indication, enables measuring |
| am_mode | input | 1 | 1 = AM base period, 0 = FM base period |
| gate_sel | input | 2 | Gate length exponent |
| gate_ext | input | 1 | Gate expand, adds 4 to the exponent |
| win_code | input | 2 | Error window exponent |
| win_ext | input | 1 | Window expand, multiplies the window by 4 |
| expect_cnt | input | CNT_W | Expected edge count per gate |
| search_stop | output | 1 | High when the last gate found a correct IF |

## Verification
A gate opens on the clock edge after lock is seen. Its verdict reaches `search_stop` one cycle after the gate's last cycle, so the first result after lock is due one gate length plus one cycle later. The bench drives a free-running IF with a four-cycle period, and every gate length used is a multiple of four. Each gate therefore holds exactly the same number of edges regardless of synchronizer phase. This lets each scenario wait two full gates plus a margin before it samples on a falling edge. Lock loss takes effect on the next rising edge and is sampled one falling edge after `pll_lock` drops. The hold check samples two cycles after `expect_cnt` changes, too soon for any gate loaded with the new value to have ended.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  // The gate exponent: 2 bits of select plus an expand bit worth 4.
  localparam int SHIFT_W = 3;
  typedef logic [SHIFT_W-1:0] shift_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_GATE = 1'b1
  } meas_state_t;

  function automatic shift_t gate_shift(input logic [1:0] sel, input logic ext);
    return shift_t'({1'b0, sel}) + (ext ? shift_t'(4) : shift_t'(0));
  endfunction

endpackage

// File: rtl/ifc_gate_timer.sv
// Sampling timer: a base prescaler followed by a power-of-two gate divider.
module ifc_gate_timer
  import ifc_pkg::*;
#(
  parameter int BASE_FM_CYC = 1640,
  parameter int BASE_AM_CYC = 10250
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   am_mode,
  input  shift_t shift,
  output logic   load,
  output logic   gate_end
);

  localparam int BASE_MAX = (BASE_AM_CYC > BASE_FM_CYC) ? BASE_AM_CYC : BASE_FM_CYC;
  localparam int BASE_W   = $clog2(BASE_MAX + 1);
  localparam int DIV_W    = (1 << SHIFT_W) - 1;

  meas_state_t       st_q, st_d;
  logic [BASE_W-1:0] base_q, base_d, base_len;
  logic [DIV_W-1:0]  div_q, div_d, div_last;
  logic              base_tick, start;

  always_comb begin
    base_len  = am_mode ? BASE_W'(BASE_AM_CYC) : BASE_W'(BASE_FM_CYC);
    div_last  = DIV_W'((32'd1 << shift) - 32'd1);
    base_tick = (st_q == ST_GATE) && (base_q == '0);
    start     = run && (st_q == ST_IDLE);
    gate_end  = run && base_tick && (div_q == div_last);
    load      = start || gate_end;
  end

  always_comb begin
    st_d   = st_q;
    base_d = base_q;
    div_d  = div_q;
    if (!run) begin
      st_d   = ST_IDLE;
      base_d = '0;
      div_d  = '0;
    end else if (start) begin
      st_d   = ST_GATE;
      base_d = base_len - BASE_W'(1);
      div_d  = '0;
    end else if (base_tick) begin
      base_d = base_len - BASE_W'(1);
      div_d  = gate_end ? '0 : div_q + DIV_W'(1);
    end else begin
      base_d = base_q - BASE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      div_q  <= '0;
    end else begin
      st_q   <= st_d;
      base_q <= base_d;
      div_q  <= div_d;
    end
  end

endmodule

// File: rtl/ifc_down_counter.sv
// Auto-reload down counter whose active length follows mode and gate length.
module ifc_down_counter
  import ifc_pkg::*;
#(
  parameter int CNT_W      = 21,
  parameter int LEN_FM_MIN = 11,
  parameter int LEN_AM_MIN = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             dec,
  input  logic             am_mode,
  input  shift_t           shift,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] resid,
  output logic [CNT_W-1:0] len_mask
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  int               act_len;

  always_comb begin
    act_len = (am_mode ? LEN_AM_MIN : LEN_FM_MIN) + int'(shift);
    if (act_len > CNT_W) act_len = CNT_W;
    for (int i = 0; i < CNT_W; i++) len_mask[i] = (i < act_len);
  end

  // Residual of the gate that ends now, counting an edge in its last cycle.
  assign resid = (cnt_q - CNT_W'(dec)) & len_mask;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (load) cnt_d = preset & len_mask;
    else if (dec)  cnt_d = (cnt_q - CNT_W'(1)) & len_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ifc_window_eval.sv
// Signed residual against a symmetric tolerance window.
module ifc_window_eval #(
  parameter int CNT_W    = 21,
  parameter int WIN_BASE = 1
) (
  input  logic [CNT_W-1:0] resid,
  input  logic [CNT_W-1:0] len_mask,
  input  logic [1:0]       win_code,
  input  logic             win_ext,
  output logic             in_win
);

  logic [CNT_W-1:0] top_bit, sext, mag, win;
  logic             neg;

  always_comb begin
    top_bit = len_mask & ~(len_mask >> 1);
    neg     = |(resid & top_bit);
    sext    = neg ? (resid | ~len_mask) : resid;
    mag     = neg ? (~sext + CNT_W'(1)) : sext;
    win     = CNT_W'(WIN_BASE) << (int'(win_code) + (win_ext ? 2 : 0));
    in_win  = (mag <= win);
  end

endmodule

// File: rtl/if_gate_counter.sv
module if_gate_counter
  import ifc_pkg::*;
#(
  parameter int CNT_W       = 21,
  parameter int LEN_FM_MIN  = 11,
  parameter int LEN_AM_MIN  = 14,
  parameter int BASE_FM_CYC = 1640,
  parameter int BASE_AM_CYC = 10250,
  parameter int WIN_BASE    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             if_in,
  input  logic             pll_lock,
  input  logic             am_mode,
  input  logic [1:0]       gate_sel,
  input  logic             gate_ext,
  input  logic [1:0]       win_code,
  input  logic             win_ext,
  input  logic [CNT_W-1:0] expect_cnt,
  output logic             search_stop
);

  logic [2:0]       sync_q, sync_d;
  logic             if_edge, load, gate_end, in_win, stop_d, stop_q;
  shift_t           shift;
  logic [CNT_W-1:0] resid, len_mask;

  // Two-stage synchronizer plus one stage for edge detection.
  assign sync_d  = {sync_q[1:0], if_in};
  assign if_edge = sync_q[1] & ~sync_q[2];
  assign shift   = gate_shift(gate_sel, gate_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  ifc_gate_timer #(
    .BASE_FM_CYC(BASE_FM_CYC),
    .BASE_AM_CYC(BASE_AM_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (pll_lock),
    .am_mode (am_mode),
    .shift   (shift),
    .load    (load),
    .gate_end(gate_end)
  );

  ifc_down_counter #(
    .CNT_W     (CNT_W),
    .LEN_FM_MIN(LEN_FM_MIN),
    .LEN_AM_MIN(LEN_AM_MIN)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (pll_lock),
    .load    (load),
    .dec     (if_edge),
    .am_mode (am_mode),
    .shift   (shift),
    .preset  (expect_cnt),
    .resid   (resid),
    .len_mask(len_mask)
  );

  ifc_window_eval #(
    .CNT_W   (CNT_W),
    .WIN_BASE(WIN_BASE)
  ) u_eval (
    .resid   (resid),
    .len_mask(len_mask),
    .win_code(win_code),
    .win_ext (win_ext),
    .in_win  (in_win)
  );

  always_comb begin
    stop_d = stop_q;
    if (!pll_lock)     stop_d = 1'b0;
    else if (gate_end) stop_d = in_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= stop_d;
  end

  assign search_stop = stop_q;

endmodule

// File: rtl/ifc_checker.sv
module ifc_checker (
  input logic clk,
  input logic rst_n,
  input logic pll_lock,
  input logic gate_end,
  input logic search_stop
);

  assert_unlocked_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock |=> !search_stop);

  assert_no_gate_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock |-> !gate_end);

  assert_gate_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |=> !gate_end);

  assert_rise_at_gate_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(search_stop) |-> $past(gate_end));

  assert_hold_between_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_lock && !gate_end) |=> $stable(search_stop));

  assert_abort_on_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_lock) |-> !gate_end);

endmodule

bind if_gate_counter ifc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pll_lock   (pll_lock),
  .gate_end   (gate_end),
  .search_stop(search_stop)
);

// File: tb/sim_if_gate_counter.sv
module sim_if_gate_counter;

  localparam int CW  = 21;
  localparam int BFM = 16;
  localparam int BAM = 40;

  logic          clk, rst_n, if_in, pll_lock, am_mode, gate_ext, win_ext;
  logic [1:0]    gate_sel, win_code;
  logic [CW-1:0] expect_cnt;
  logic          search_stop;

  int n_checks = 0;
  int n_fail   = 0;

  if_gate_counter #(
    .CNT_W(CW), .LEN_FM_MIN(11), .LEN_AM_MIN(14),
    .BASE_FM_CYC(BFM), .BASE_AM_CYC(BAM), .WIN_BASE(1)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .if_in(if_in), .pll_lock(pll_lock),
    .am_mode(am_mode), .gate_sel(gate_sel), .gate_ext(gate_ext),
    .win_code(win_code), .win_ext(win_ext), .expect_cnt(expect_cnt),
    .search_stop(search_stop)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // IF with a 4-cycle period: any gate of 4k cycles holds exactly k edges.
  initial begin
    if_in = 1'b0;
    forever begin
      repeat (2) @(negedge clk);
      if_in = ~if_in;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: search_stop actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic measure(input logic am, input logic [1:0] sel, input logic ext,
                         input logic [1:0] code, input logic wext,
                         input logic [CW-1:0] exp_cnt, input int gate_len);
    pll_lock = 1'b0;
    repeat (2) @(negedge clk);
    am_mode = am; gate_sel = sel; gate_ext = ext;
    win_code = code; win_ext = wext; expect_cnt = exp_cnt;
    @(negedge clk);
    pll_lock = 1'b1;
    repeat (2 * gate_len + 20) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset", search_stop, 1'b0);
  endtask

  task automatic t_no_lock();
    am_mode = 0; gate_sel = 0; gate_ext = 0; win_code = 0; win_ext = 0;
    expect_cnt = CW'(4);
    repeat (200) @(negedge clk);
    check("R2 unlocked", search_stop, 1'b0);
  endtask

  task automatic t_fm_gate();
    measure(0, 2'd0, 0, 2'd0, 0, CW'(4), BFM);
    check("R3 R6 fm sel0 exact", search_stop, 1'b1);
    measure(0, 2'd0, 0, 2'd0, 0, CW'(5), BFM);
    check("R7 fm residual +1 in window 1", search_stop, 1'b1);
    measure(0, 2'd0, 0, 2'd0, 0, CW'(6), BFM);
    check("R7 fm residual +2 outside window 1", search_stop, 1'b0);
    measure(0, 2'd1, 0, 2'd0, 0, CW'(8), 2 * BFM);
    check("R3 fm sel1 count 8", search_stop, 1'b1);
    measure(0, 2'd1, 0, 2'd0, 0, CW'(4), 2 * BFM);
    check("R3 fm sel1 not count 4", search_stop, 1'b0);
    measure(0, 2'd0, 1, 2'd0, 0, CW'(64), 16 * BFM);
    check("R3 fm gate expand count 64", search_stop, 1'b1);
  endtask

  task automatic t_am_gate();
    measure(1, 2'd0, 0, 2'd0, 0, CW'(10), BAM);
    check("R4 am sel0 count 10", search_stop, 1'b1);
    measure(1, 2'd0, 0, 2'd0, 0, CW'(4), BAM);
    check("R4 am sel0 not fm count", search_stop, 1'b0);
  endtask

  task automatic t_truncate();
    measure(0, 2'd0, 0, 2'd0, 0, CW'(4 + 2048), BFM);
    check("R5 fm bit 11 ignored", search_stop, 1'b1);
    measure(1, 2'd0, 0, 2'd0, 0, CW'(10 + 16384), BAM);
    check("R5 am bit 14 ignored", search_stop, 1'b1);
    measure(0, 2'd0, 0, 2'd0, 0, CW'(4 + 1024), BFM);
    check("R5 fm bit 10 counts", search_stop, 1'b0);
  endtask

  task automatic t_negative();
    measure(0, 2'd0, 0, 2'd1, 0, CW'(2), BFM);
    check("R6 R7 residual -2 in window 2", search_stop, 1'b1);
    measure(0, 2'd0, 0, 2'd1, 0, CW'(1), BFM);
    check("R6 R7 residual -3 outside window 2", search_stop, 1'b0);
  endtask

  task automatic t_window();
    measure(0, 2'd0, 0, 2'd0, 1, CW'(8), BFM);
    check("R7 expand window 4 at +4", search_stop, 1'b1);
    measure(0, 2'd0, 0, 2'd0, 1, CW'(9), BFM);
    check("R7 expand window 4 at +5", search_stop, 1'b0);
    measure(0, 2'd0, 0, 2'd3, 0, CW'(12), BFM);
    check("R7 window 8 at +8", search_stop, 1'b1);
  endtask

  task automatic t_hold();
    measure(0, 2'd0, 0, 2'd0, 0, CW'(4), BFM);
    check("R8 matched before change", search_stop, 1'b1);
    expect_cnt = CW'(40);
    repeat (2) @(negedge clk);
    check("R8 held until gate end", search_stop, 1'b1);
    repeat (2 * BFM + 20) @(negedge clk);
    check("R8 reload picks new preset", search_stop, 1'b0);
  endtask

  task automatic t_unlock();
    measure(0, 2'd0, 0, 2'd0, 0, CW'(4), BFM);
    check("R9 locked high", search_stop, 1'b1);
    pll_lock = 1'b0;
    @(negedge clk);
    check("R9 cleared next edge", search_stop, 1'b0);
    repeat (3 * BFM) @(negedge clk);
    check("R9 stays low unlocked", search_stop, 1'b0);
    pll_lock = 1'b1;
    repeat (2 * BFM + 20) @(negedge clk);
    check("R9 relock measures again", search_stop, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; pll_lock = 1'b0; am_mode = 1'b0; gate_sel = '0; gate_ext = 1'b0;
    win_code = '0; win_ext = 1'b0; expect_cnt = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_no_lock();
    t_fm_gate();
    t_am_gate();
    t_truncate();
    t_negative();
    t_window();
    t_hold();
    t_unlock();
    finish_run();
  end

endmodule